// File: doc/BRIEF.md
# Sound Unit Register Bank

This block is the byte-addressed register file in front of a four-channel sound generator. It holds each channel's control bytes (sweep, length and duty, envelope or level, frequency low byte, frequency high byte with trigger), the master volume and panning bytes, a power register, and a 16-byte wave sample memory. The storage is exposed as flat vectors so the synthesis logic can read it directly. The CPU reaches all of it through a single write port and a combinational read port.

The power bit gates the whole bank. Clearing it wipes every channel and mixer byte in the same clock edge. After that, writes to those bytes are dropped, with the exceptions the older model (`model_new_i = 0`) makes for length fields. The wave memory stays reachable at all times. While channel 3 is playing, its accesses are steered to the byte the channel is currently fetching. The exact steering depends on the model select and on a readable flag supplied by the channel-3 engine. Reads OR in a fixed mask of ones per register, so unused bits read back as 1.

Top module: `snd_regbank`

Address map (6-bit `addr_i`):
- For addr[5]=0 and addr[2:0] in 0..4: channel c = addr[4:3] (0 is channel 1) and slot s = addr[2:0]. The slots are: 0 = channel control (sweep on channel 1, DAC enable on channel 3), 1 = length, 2 = envelope/level, 3 = frequency low (noise shape on channel 4), 4 = frequency high with trigger.
- Mixer bytes: 0x05 is master volume, 0x06 is panning, 0x07 is power.
- 0x20 to 0x2F is wave memory, byte n at 0x20+n.

## Requirements
- R1: With power on, a write to a mapped channel byte stores the value. Channel c slot s appears at bits [(c*5+s)*8 +: 8] of `ch_regs_o`. The volume and panning bytes appear on their own outputs.
- R2: A channel or mixer read returns the stored value ORed with a mask:
  - channel 1 slots 0..4: 0x80, 0x3F, 0x00, 0xFF, 0xBF
  - channel 2 slots 1..4: 0x3F, 0x00, 0xFF, 0xBF
  - channel 3 slots 0..4: 0x7F, 0xFF, 0x9F, 0xFF, 0xBF
  - channel 4 slots 1..4: 0xFF, 0x00, 0x00, 0xBF
  - volume and panning: 0x00
- R3: After reset, power is on, volume is 0x77 and panning is 0xF3. Channel 1 slot 0 is 0x80, channel 1 slot 2 is 0xF3, and every other channel byte is 0.
- R4: A write to 0x07 stores only bit 7 as the power bit. A read of 0x07 returns {power, 3'b111, ch_active_i[3:0]}.
- R5: Writing 0x07 with bit 7 clear zeroes all channel bytes, volume and panning on that same edge.
- R6: While power is off, writes to volume, panning and channel bytes other than slot 1 leave them unchanged. On the newer model, slot 1 writes are also dropped.
- R7: While power is off on the older model, slot 1 of channels 3 and 4 stores the full written byte, and slot 1 of channels 1 and 2 stores the written byte ANDed with 0x3F.
- R8: While channel 3 is not playing, wave reads and writes use byte addr[3:0], regardless of power.
- R9: While channel 3 plays on the older model, a wave read returns byte ch3_pos_i[4:1] when readable is set and 0xFF otherwise. A wave write goes to byte ch3_pos_i[4:1] only when readable is set; otherwise it is dropped.
- R10: While channel 3 plays on the newer model, a wave read returns byte ch3_pos_i[4:1] and a wave write goes to the addressed byte.
- R11: Unmapped addresses read 0xFF and writes to them change no output. The unmapped addresses are 0x08, 0x18, 0x0D-0x0F, 0x15-0x17, 0x1D-0x1F and 0x30-0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 6 | Byte address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| ch_active_i | input | 4 | Per-channel running status, bit 0 is channel 1 |
| ch3_playing_i | input | 1 | Channel 3 is playing |
| ch3_readable_i | input | 1 | Channel 3 fetch window is open |
| ch3_pos_i | input | 5 | Channel 3 sample position (32 samples) |
| model_new_i | input | 1 | 1 selects the newer model's rules |
| power_on_o | output | 1 | Master enable bit |
| ch_regs_o | output | 160 | Stored channel bytes, 20 bytes flat |
| master_vol_o | output | 8 | Stored master volume |
| pan_o | output | 8 | Stored panning |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the same-edge wipe on power-down
- channel and mixer bytes holding still while powered off
- the 0x3F length mask on older-model off writes
- the composition of the power read
- the 0xFF returned by unmapped addresses and by a locked wave window

Other behaviours can only be shown by the bench's scenarios, because they need values written earlier to be recalled:
- the per-register read masks
- reset contents
- redirection of wave writes to the playback byte
- the newer model's split between read and write targets

// File: rtl/snd_regbank_pkg.sv
`timescale 1ns/1ps
package snd_regbank_pkg;

  localparam int BYTE_W   = 8;
  localparam int LEN_SLOT = 1;

  typedef enum logic [1:0] {
    KIND_CHAN = 2'd0,
    KIND_MIX  = 2'd1,
    KIND_WAVE = 2'd2,
    KIND_NONE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MIX_VOL = 2'd1,
    MIX_PAN = 2'd2,
    MIX_PWR = 2'd3
  } mix_sel_e;

  // Channels 2 and 4 have no slot-0 byte; slots above 4 are not channel bytes.
  function automatic logic chan_slot_mapped(int c, int s);
    if (s > 4) return 1'b0;
    if (s == 0 && (c == 1 || c == 3)) return 1'b0;
    return 1'b1;
  endfunction

  // Constant ones ORed into read data.
  function automatic logic [BYTE_W-1:0] chan_read_mask(int c, int s);
    logic [BYTE_W-1:0] m;
    m = 8'hFF;
    case (c)
      0: case (s)
           0: m = 8'h80; 1: m = 8'h3F; 2: m = 8'h00; 3: m = 8'hFF; 4: m = 8'hBF;
           default: m = 8'hFF;
         endcase
      1: case (s)
           1: m = 8'h3F; 2: m = 8'h00; 3: m = 8'hFF; 4: m = 8'hBF;
           default: m = 8'hFF;
         endcase
      2: case (s)
           0: m = 8'h7F; 1: m = 8'hFF; 2: m = 8'h9F; 3: m = 8'hFF; 4: m = 8'hBF;
           default: m = 8'hFF;
         endcase
      default: case (s)
           1: m = 8'hFF; 2: m = 8'h00; 3: m = 8'h00; 4: m = 8'hBF;
           default: m = 8'hFF;
         endcase
    endcase
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] chan_reset_value(int c, int s);
    if (c == 0 && s == 0) return 8'h80;
    if (c == 0 && s == 2) return 8'hF3;
    return 8'h00;
  endfunction

  // Returns {accept, stored value} for a channel-byte write under power gating.
  function automatic logic [BYTE_W:0] gate_write(int c, int s, logic pwr_on,
                                                 logic model_new, logic [BYTE_W-1:0] d);
    if (pwr_on) return {1'b1, d};
    if (s == LEN_SLOT && !model_new) begin
      if (c >= 2) return {1'b1, d};
      return {1'b1, d & 8'h3F};
    end
    return {1'b0, 8'h00};
  endfunction

  // Byte currently fetched by channel 3: two samples per byte.
  function automatic logic [3:0] play_byte(logic [4:0] pos);
    return pos[4:1];
  endfunction

endpackage

// File: rtl/snd_addr_decode.sv
`timescale 1ns/1ps
module snd_addr_decode
  import snd_regbank_pkg::*;
#(
  parameter int AW      = 6,
  parameter int CH_W    = 2,
  parameter int SLOT_W  = 3,
  parameter int WIDX_W  = 4
) (
  input  logic [AW-1:0]     addr_i,
  output acc_kind_e         kind_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [SLOT_W-1:0] slot_o,
  output mix_sel_e          mix_o,
  output logic [WIDX_W-1:0] widx_o
);
  localparam int WAVE_BIT = AW - 1;

  always_comb begin
    ch_o   = addr_i[SLOT_W +: CH_W];
    slot_o = addr_i[SLOT_W-1:0];
    widx_o = addr_i[WIDX_W-1:0];
    mix_o  = MIX_VOL;
    kind_o = KIND_NONE;
    if (addr_i[WAVE_BIT]) begin
      if (!addr_i[WAVE_BIT-1]) kind_o = KIND_WAVE;
    end else if (chan_slot_mapped(int'(ch_o), int'(slot_o))) begin
      kind_o = KIND_CHAN;
    end else if (ch_o == '0) begin
      kind_o = KIND_MIX;
      case (slot_o)
        3'd5:    mix_o = MIX_VOL;
        3'd6:    mix_o = MIX_PAN;
        default: mix_o = MIX_PWR;
      endcase
    end
  end
endmodule

// File: rtl/snd_chan_regs.sv
`timescale 1ns/1ps
module snd_chan_regs
  import snd_regbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOTS  = 5,
  parameter int DW     = BYTE_W,
  parameter int CH_W   = 2,
  parameter int SLOT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [CH_W-1:0]           ch_i,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      pwr_on_i,
  input  logic                      model_new_i,
  input  logic                      clear_i,
  output logic [NUM_CH*SLOTS*DW-1:0] regs_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DW-1:0] q;
      logic [DW:0]   gated;
      logic          hit;
      assign gated = gate_write(c, s, pwr_on_i, model_new_i, wdata_i);
      assign hit   = wr_i && (ch_i == CH_W'(c)) && (slot_i == SLOT_W'(s)) && gated[DW];
      always_ff @(posedge clk) begin
        if (!rst_n)       q <= chan_reset_value(c, s);
        else if (clear_i) q <= '0;
        else if (hit)     q <= gated[DW-1:0];
      end
      assign regs_o[(c*SLOTS+s)*DW +: DW] = q;
    end
  end
endmodule

// File: rtl/snd_mix_regs.sv
`timescale 1ns/1ps
module snd_mix_regs
  import snd_regbank_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter logic [DW-1:0] VOL_RST = 8'h77,
  parameter logic [DW-1:0] PAN_RST = 8'hF3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  mix_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pwr_on_o,
  output logic [DW-1:0] vol_o,
  output logic [DW-1:0] pan_o,
  output logic          clear_o
);
  logic pwr_wr;
  assign pwr_wr  = wr_i && (sel_i == MIX_PWR);
  assign clear_o = pwr_wr && !wdata_i[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_on_o <= 1'b1;
      vol_o    <= VOL_RST;
      pan_o    <= PAN_RST;
    end else if (clear_o) begin
      pwr_on_o <= 1'b0;
      vol_o    <= '0;
      pan_o    <= '0;
    end else if (pwr_wr) begin
      pwr_on_o <= 1'b1;
    end else if (wr_i && pwr_on_o) begin
      if (sel_i == MIX_VOL) vol_o <= wdata_i;
      if (sel_i == MIX_PAN) pan_o <= wdata_i;
    end
  end
endmodule

// File: rtl/snd_wave_ram.sv
`timescale 1ns/1ps
module snd_wave_ram
  import snd_regbank_pkg::*;
#(
  parameter int DW     = BYTE_W,
  parameter int NBYTES = 16,
  localparam int IW    = $clog2(NBYTES),
  localparam int PW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          playing_i,
  input  logic          readable_i,
  input  logic [PW-1:0] pos_i,
  input  logic          model_new_i,
  output logic [DW-1:0] rdata_o,
  output logic          wr_ok_o,
  output logic [IW-1:0] wr_idx_o
);
  logic [DW-1:0] mem [NBYTES];
  logic [IW-1:0] play_idx;
  logic          follow_play;

  assign play_idx    = play_byte(pos_i);
  assign follow_play = playing_i && !model_new_i;

  always_comb begin
    wr_idx_o = idx_i;
    wr_ok_o  = wr_i;
    if (follow_play) begin
      wr_idx_o = play_idx;
      wr_ok_o  = wr_i && readable_i;
    end
  end

  always_comb begin
    if (!playing_i)                     rdata_o = mem[idx_i];
    else if (model_new_i || readable_i) rdata_o = mem[play_idx];
    else                                rdata_o = '1;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                                    mem[b] <= '0;
      else if (wr_ok_o && (wr_idx_o == IW'(b)))       mem[b] <= wdata_i;
    end
  end
endmodule

// File: rtl/snd_regbank.sv
`timescale 1ns/1ps
module snd_regbank
  import snd_regbank_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int SLOTS      = 5,
  parameter int DW         = BYTE_W,
  parameter int WAVE_BYTES = 16,
  parameter int AW         = 6,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int SLOT_W    = 3,
  localparam int WIDX_W    = $clog2(WAVE_BYTES),
  localparam int NREG      = NUM_CH * SLOTS,
  localparam int RIDX_W    = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr_i,
  input  logic                 wr_en_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]    ch_active_i,
  input  logic                 ch3_playing_i,
  input  logic                 ch3_readable_i,
  input  logic [WIDX_W:0]      ch3_pos_i,
  input  logic                 model_new_i,
  output logic                 power_on_o,
  output logic [NREG*DW-1:0]   ch_regs_o,
  output logic [DW-1:0]        master_vol_o,
  output logic [DW-1:0]        pan_o
);
  acc_kind_e           kind;
  logic [CH_W-1:0]     ch_sel;
  logic [SLOT_W-1:0]   slot_sel;
  mix_sel_e            mix_sel;
  logic [WIDX_W-1:0]   wave_idx;
  logic                chan_wr, mix_wr, wave_wr;
  logic                pwr_clear;
  logic [DW-1:0]       wave_rdata;
  logic                wave_wr_ok;
  logic [WIDX_W-1:0]   wave_wr_idx;
  logic [DW-1:0]       chan_arr [NREG];
  logic [RIDX_W-1:0]   reg_sel;

  snd_addr_decode #(.AW(AW), .CH_W(CH_W), .SLOT_W(SLOT_W), .WIDX_W(WIDX_W)) u_dec (
    .addr_i(addr_i), .kind_o(kind), .ch_o(ch_sel), .slot_o(slot_sel),
    .mix_o(mix_sel), .widx_o(wave_idx)
  );

  assign chan_wr = wr_en_i && (kind == KIND_CHAN);
  assign mix_wr  = wr_en_i && (kind == KIND_MIX);
  assign wave_wr = wr_en_i && (kind == KIND_WAVE);

  snd_mix_regs #(.DW(DW)) u_mix (
    .clk(clk), .rst_n(rst_n), .wr_i(mix_wr), .sel_i(mix_sel), .wdata_i(wdata_i),
    .pwr_on_o(power_on_o), .vol_o(master_vol_o), .pan_o(pan_o), .clear_o(pwr_clear)
  );

  snd_chan_regs #(.NUM_CH(NUM_CH), .SLOTS(SLOTS), .DW(DW), .CH_W(CH_W), .SLOT_W(SLOT_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .wr_i(chan_wr), .ch_i(ch_sel), .slot_i(slot_sel),
    .wdata_i(wdata_i), .pwr_on_i(power_on_o), .model_new_i(model_new_i),
    .clear_i(pwr_clear), .regs_o(ch_regs_o)
  );

  snd_wave_ram #(.DW(DW), .NBYTES(WAVE_BYTES)) u_wave (
    .clk(clk), .rst_n(rst_n), .wr_i(wave_wr), .idx_i(wave_idx), .wdata_i(wdata_i),
    .playing_i(ch3_playing_i), .readable_i(ch3_readable_i), .pos_i(ch3_pos_i),
    .model_new_i(model_new_i), .rdata_o(wave_rdata), .wr_ok_o(wave_wr_ok),
    .wr_idx_o(wave_wr_idx)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_arr
    assign chan_arr[r] = ch_regs_o[r*DW +: DW];
  end

  assign reg_sel = RIDX_W'(ch_sel) * RIDX_W'(SLOTS) + RIDX_W'(slot_sel);

  always_comb begin
    rdata_o = '1;
    unique case (kind)
      KIND_CHAN: rdata_o = chan_arr[reg_sel] | chan_read_mask(int'(ch_sel), int'(slot_sel));
      KIND_MIX: begin
        case (mix_sel)
          MIX_VOL: rdata_o = master_vol_o;
          MIX_PAN: rdata_o = pan_o;
          default: rdata_o = {power_on_o, 3'b111, ch_active_i};
        endcase
      end
      KIND_WAVE: rdata_o = wave_rdata;
      default:   rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/snd_regbank_chk.sv
`timescale 1ns/1ps
module snd_regbank_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [5:0]   addr_i,
  input logic         wr_en_i,
  input logic [7:0]   wdata_i,
  input logic [7:0]   rdata_o,
  input logic [3:0]   ch_active_i,
  input logic         ch3_playing_i,
  input logic         ch3_readable_i,
  input logic         model_new_i,
  input logic         power_on_o,
  input logic [159:0] ch_regs_o,
  input logic [7:0]   master_vol_o,
  input logic [7:0]   pan_o,
  input logic         wave_wr_ok
);
  logic is_pwr, is_len_slot, is_unmapped, is_wave, pwr_down_wr, old_len_wr;
  assign is_pwr      = (addr_i == 6'h07);
  assign is_len_slot = !addr_i[5] && (addr_i[2:0] == 3'd1);
  assign is_wave     = (addr_i[5:4] == 2'b10);
  assign is_unmapped = (addr_i[5:4] == 2'b11) || addr_i == 6'h08 || addr_i == 6'h18 ||
                       (!addr_i[5] && addr_i[4:3] != 2'd0 && addr_i[2:0] >= 3'd5);
  assign pwr_down_wr = wr_en_i && is_pwr && !wdata_i[7];
  assign old_len_wr  = wr_en_i && is_len_slot && !model_new_i;

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_wr |=> (ch_regs_o == '0 && master_vol_o == 8'h00 && pan_o == 8'h00 && !power_on_o));

  a_r6_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_on_o && !old_len_wr) |=> $stable(ch_regs_o));

  a_r6_mix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on_o |=> ($stable(master_vol_o) && $stable(pan_o)));

  a_r7_len_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_on_o && old_len_wr && addr_i == 6'h01) |=> (ch_regs_o[15:8] == ($past(wdata_i) & 8'h3F)));

  a_r4_power_read: assert property (@(posedge clk) disable iff (!rst_n)
    is_pwr |-> (rdata_o == {power_on_o, 3'b111, ch_active_i}));

  a_r11_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    is_unmapped |-> (rdata_o == 8'hFF));

  a_r9_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wave && ch3_playing_i && !ch3_readable_i && !model_new_i) |-> (rdata_o == 8'hFF));

  a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ch3_playing_i && !ch3_readable_i && !model_new_i) |-> !wave_wr_ok);
endmodule

bind snd_regbank snd_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .ch_active_i(ch_active_i), .ch3_playing_i(ch3_playing_i),
  .ch3_readable_i(ch3_readable_i), .model_new_i(model_new_i), .power_on_o(power_on_o),
  .ch_regs_o(ch_regs_o), .master_vol_o(master_vol_o), .pan_o(pan_o),
  .wave_wr_ok(wave_wr_ok)
);

// File: tb/snd_regbank_tb.sv
`timescale 1ns/1ps
module snd_regbank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [3:0]   active = 4'h1;
  logic         playing = 1'b0, readable = 1'b0;
  logic [4:0]   pos = '0;
  logic         model_new = 1'b0;
  logic         pwr;
  logic [159:0] regs;
  logic [7:0]   vol, pan;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  snd_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .ch_active_i(active), .ch3_playing_i(playing),
    .ch3_readable_i(readable), .ch3_pos_i(pos), .model_new_i(model_new),
    .power_on_o(pwr), .ch_regs_o(regs), .master_vol_o(vol), .pan_o(pan)
  );

  function automatic logic [7:0] exp_mask(int c, int s);
    logic [7:0] t [4][5] = '{
      '{8'h80, 8'h3F, 8'h00, 8'hFF, 8'hBF},
      '{8'hFF, 8'h3F, 8'h00, 8'hFF, 8'hBF},
      '{8'h7F, 8'hFF, 8'h9F, 8'hFF, 8'hBF},
      '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'hBF}};
    return t[c][s];
  endfunction

  function automatic logic [7:0] reg_byte(int c, int s);
    return regs[(c*5+s)*8 +: 8];
  endfunction

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R3 power_on", 160'(pwr), 160'(1));
    rd(6'h05, d); chk("R3 volume", 160'(d), 160'(8'h77));
    rd(6'h06, d); chk("R3 panning", 160'(d), 160'(8'hF3));
    rd(6'h07, d); chk("R3 R4 power read", 160'(d), 160'(8'hF1));
    chk("R3 sweep", 160'(reg_byte(0, 0)), 160'(8'h80));
    chk("R3 envelope", 160'(reg_byte(0, 2)), 160'(8'hF3));
    chk("R3 ch3 level", 160'(reg_byte(2, 2)), 160'(0));
  endtask

  task automatic t_masks();
    logic [7:0] d;
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 5; s++) begin
        if (!(s == 0 && (c == 1 || c == 3))) begin
          wr(6'(c*8+s), 8'h00);
          rd(6'(c*8+s), d);
          chk("R2 mask", 160'(d), 160'(exp_mask(c, s)));
          wr(6'(c*8+s), 8'hA5);
          rd(6'(c*8+s), d);
          chk("R2 value or mask", 160'(d), 160'(8'hA5 | exp_mask(c, s)));
          chk("R1 stored byte", 160'(reg_byte(c, s)), 160'(8'hA5));
        end
      end
    end
    wr(6'h05, 8'h3C); rd(6'h05, d); chk("R1 volume", 160'(d), 160'(8'h3C));
    wr(6'h06, 8'hC3); chk("R1 pan output", 160'(pan), 160'(8'hC3));
  endtask

  task automatic t_power();
    logic [7:0] d;
    active = 4'b0101;
    wr(6'h07, 8'h7F);
    chk("R5 channel bytes cleared", regs, 160'(0));
    chk("R5 volume cleared", 160'(vol), 160'(0));
    chk("R5 pan cleared", 160'(pan), 160'(0));
    rd(6'h07, d); chk("R4 power read off", 160'(d), 160'(8'h75));
    model_new = 1'b1;
    wr(6'h02, 8'h77); chk("R6 env ignored", 160'(reg_byte(0, 2)), 160'(0));
    wr(6'h05, 8'h44); rd(6'h05, d); chk("R6 volume ignored", 160'(d), 160'(0));
    wr(6'h01, 8'hFF); chk("R6 new model length ignored", 160'(reg_byte(0, 1)), 160'(0));
    model_new = 1'b0;
    wr(6'h01, 8'hFF); chk("R7 ch1 length masked", 160'(reg_byte(0, 1)), 160'(8'h3F));
    wr(6'h09, 8'hC7); chk("R7 ch2 length masked", 160'(reg_byte(1, 1)), 160'(8'h07));
    wr(6'h11, 8'hAB); chk("R7 ch3 length full", 160'(reg_byte(2, 1)), 160'(8'hAB));
    wr(6'h19, 8'h55); chk("R7 ch4 length full", 160'(reg_byte(3, 1)), 160'(8'h55));
    wr(6'h12, 8'h66); chk("R6 old model level ignored", 160'(reg_byte(2, 2)), 160'(0));
    wr(6'h07, 8'h80);
    rd(6'h07, d); chk("R4 power read on", 160'(d), 160'(8'hF5));
    chk("R4 power on keeps bytes", 160'(reg_byte(2, 1)), 160'(8'hAB));
    wr(6'h02, 8'h19); chk("R1 write after power on", 160'(reg_byte(0, 2)), 160'(8'h19));
  endtask

  task automatic t_wave_idle();
    logic [7:0] d;
    wr(6'h07, 8'h00);
    for (int b = 0; b < 16; b++) wr(6'(32+b), 8'(b*17));
    for (int b = 0; b < 16; b += 5) begin
      rd(6'(32+b), d); chk("R8 wave idle while off", 160'(d), 160'(b*17));
    end
    wr(6'h07, 8'h80);
  endtask

  task automatic t_wave_old();
    logic [7:0] d;
    model_new = 1'b0; playing = 1'b1; readable = 1'b1; pos = 5'd6;
    rd(6'h2A, d); chk("R9 read follows position", 160'(d), 160'(8'h33));
    readable = 1'b0;
    rd(6'h2A, d); chk("R9 locked read", 160'(d), 160'(8'hFF));
    wr(6'h2A, 8'h11);
    readable = 1'b1;
    wr(6'h20, 8'hE7);
    playing = 1'b0;
    rd(6'h23, d); chk("R9 write to play byte", 160'(d), 160'(8'hE7));
    rd(6'h20, d); chk("R9 addressed byte untouched", 160'(d), 160'(8'h00));
    rd(6'h2A, d); chk("R9 locked write dropped", 160'(d), 160'(8'hAA));
  endtask

  task automatic t_wave_new();
    logic [7:0] d;
    model_new = 1'b1; playing = 1'b1; readable = 1'b0; pos = 5'd11;
    rd(6'h21, d); chk("R10 read follows position", 160'(d), 160'(8'h55));
    wr(6'h28, 8'h9C);
    playing = 1'b0;
    rd(6'h28, d); chk("R10 write to addressed byte", 160'(d), 160'(8'h9C));
    rd(6'h25, d); chk("R10 play byte untouched", 160'(d), 160'(8'h55));
    model_new = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [159:0] snap;
    logic [7:0] v, p;
    snap = regs; v = vol; p = pan;
    rd(6'h08, d); chk("R11 ch2 slot0 read", 160'(d), 160'(8'hFF));
    rd(6'h1D, d); chk("R11 ch4 slot5 read", 160'(d), 160'(8'hFF));
    rd(6'h35, d); chk("R11 upper range read", 160'(d), 160'(8'hFF));
    wr(6'h08, 8'h12); wr(6'h18, 8'h34); wr(6'h16, 8'h56); wr(6'h3F, 8'h78);
    chk("R11 writes no effect regs", regs, snap);
    chk("R11 writes no effect mix", 160'({v, p}), 160'({vol, pan}));
    rd(6'h2F, d); chk("R11 wave not aliased", 160'(d), 160'(8'hFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_power();
    t_wave_idle();
    t_wave_old();
    t_wave_new();
    t_unmapped();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule